// File: doc/BRIEF.md
# Performance Counter Bank

This block holds a set of event counters and one free-running cycle counter, all reached through one simple register port. A control register enables counting, clears the event counters on request and reports how many event counters are in use. That number can be lowered by software, but it can never be raised past the number of counters built into the hardware. Each event counter has a count value and an event-type value. Both can be reached directly at a per-counter address, or indirectly by writing a counter number into a selector and then using one shared data address.

Counter enable, interrupt enable and overflow status are each kept as a 32-bit bitmap. Each bitmap has a set address and a clear address, and both addresses read back the same bitmap. An event counter advances on its own event pulse input. An access to the count or type of a counter that is not in use does nothing and raises an error flag. Overflow bits combine with the interrupt-enable bits to drive one interrupt line.

Register map (8-bit word address): 0x00 control, 0x01 selector, 0x02 selected count, 0x03 selected type, 0x04 cycle count, 0x08/0x09 counter-enable set/clear, 0x0A/0x0B interrupt-enable set/clear, 0x0C/0x0D overflow set/clear. The count of counter k is at 0x20+k and its type at 0x40+k. Unmapped addresses read zero and raise no error.

Top module: `pmu_counter_bank`

## Requirements
- R1: After reset, the control register reads with enable (bit 0) clear and the in-use count (bits 15:11) equal to HW_CTRS. All bitmaps read zero, irq_o is low and every count reads zero.
- R2: A control write whose bits 15:11 hold a value no greater than HW_CTRS changes the in-use count to that value. A larger value leaves the count unchanged, and the write raises no error.
- R3: Writing ones to a set address sets those bits, and writing ones to the matching clear address clears them. Both addresses read the same bitmap. Bit 31 belongs to the cycle counter and bit k to event counter k.
- R4: Bitmap bits for event counters k >= the in-use count N read zero and ignore writes. Lowering N clears them, so raising N again still shows them as zero.
- R5: A counter k < N returns the value last written to its count at 0x20+k and to its type at 0x40+k.
- R6: With the selector (bits 4:0 at 0x01) holding k, the addresses 0x02 and 0x03 read and write the same storage as the direct addresses of counter k.
- R7: A read or write of the count or type of a counter k >= N, whether direct or through the selector, drives reg_err_o high in that cycle and changes no counter or type value. A valid access keeps reg_err_o low.
- R8: A type register keeps bits 15:0 (the event number) and bit 31 (an exclude flag) exactly as written, and reads all other bits as zero.
- R9: An event counter k advances by one on a clock where event_i[k] is high, the enable bit is set and enable bit k is set. When enable is clear, no counter moves.
- R10: A control write with bit 1 set clears every event counter to zero. Bit 1 always reads back as zero.
- R11: When an event counter wraps from all ones to zero, its overflow bit is set. irq_o is high exactly when some bit is set in both the overflow and the interrupt-enable bitmaps.
- R12: The cycle counter (0x04) advances on every clock where enable and bitmap bit 31 are both set. When it wraps, it sets overflow bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | One-cycle write strobe |
| reg_rd_i | input | 1 | Read qualifier, used only for error reporting |
| reg_addr_i | input | 8 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the address |
| reg_err_o | output | 1 | Access to a counter that is not in use |
| event_i | input | HW_CTRS | Per-counter event pulses |
| irq_o | output | 1 | Overflow interrupt |

## Verification
Counting is tried with random event patterns under a random enable mask, and then with all events high while the global enable is off. This separates gating by the global enable from gating by each counter's own enable bit. Counter storage is reached through every mix of direct and selector paths, so a fault in only one path shows up. Preloaded all-ones values and the cycle counter expose the wrap and overflow path. Writes placed just above the in-use count, before and after it is lowered, separate a bitmap that is only masked on read from one that is truly cleared.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned AW      = 8;
  localparam int unsigned IDXW    = 5;
  localparam int unsigned CYC_BIT = 31;

  localparam logic [AW-1:0] A_CTRL     = 8'h00;
  localparam logic [AW-1:0] A_SEL      = 8'h01;
  localparam logic [AW-1:0] A_SDAT_CNT = 8'h02;
  localparam logic [AW-1:0] A_SDAT_TYP = 8'h03;
  localparam logic [AW-1:0] A_CYC      = 8'h04;
  localparam logic [AW-1:0] A_CEN_SET  = 8'h08;
  localparam logic [AW-1:0] A_CEN_CLR  = 8'h09;
  localparam logic [AW-1:0] A_IEN_SET  = 8'h0A;
  localparam logic [AW-1:0] A_IEN_CLR  = 8'h0B;
  localparam logic [AW-1:0] A_OVF_SET  = 8'h0C;
  localparam logic [AW-1:0] A_OVF_CLR  = 8'h0D;
  localparam logic [AW-IDXW-1:0] PAGE_CNT = 3'd1;
  localparam logic [AW-IDXW-1:0] PAGE_TYP = 3'd2;

  localparam int unsigned CTRL_EN    = 0;
  localparam int unsigned CTRL_RST   = 1;
  localparam int unsigned CTRL_N_LSB = 11;
  localparam logic [DW-1:0] TYPE_KEEP = 32'h8000_FFFF;

  typedef enum logic [3:0] {
    K_NONE, K_CTRL, K_SEL, K_CYC,
    K_CEN_S, K_CEN_C, K_IEN_S, K_IEN_C, K_OVF_S, K_OVF_C,
    K_CNT, K_TYP
  } kind_e;

  typedef struct packed {
    kind_e           kind;
    logic [IDXW-1:0] idx;
  } dec_t;

  // bitmap of counters in use: event counters below n plus the cycle counter
  function automatic logic [DW-1:0] impl_mask(input logic [IDXW-1:0] n);
    logic [DW-1:0] m;
    m = '0;
    m[CYC_BIT] = 1'b1;
    for (int i = 0; i < int'(CYC_BIT); i++)
      if (i < int'(n)) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [DW-1:0] bitmap_next(input logic [DW-1:0] q,
                                                input logic [DW-1:0] setv,
                                                input logic [DW-1:0] clrv,
                                                input logic [DW-1:0] hw,
                                                input logic [DW-1:0] mask);
    return (((q | setv) & ~clrv) | hw) & mask;
  endfunction

  function automatic logic [IDXW-1:0] n_accept(input logic [IDXW-1:0] cur,
                                               input logic [IDXW-1:0] req,
                                               input logic [IDXW-1:0] limit);
    return (req <= limit) ? req : cur;
  endfunction
endpackage

// File: rtl/pmu_addr_decode.sv
module pmu_addr_decode
  import pmu_pkg::*;
(
  input  logic [AW-1:0]   addr_i,
  input  logic [IDXW-1:0] sel_i,
  input  logic [IDXW-1:0] n_i,
  input  logic            wr_i,
  input  logic            rd_i,
  output dec_t            dec_o,
  output logic            idx_ok_o,
  output logic            err_o
);
  always_comb begin
    dec_o.kind = K_NONE;
    dec_o.idx  = '0;
    case (addr_i)
      A_CTRL:     dec_o.kind = K_CTRL;
      A_SEL:      dec_o.kind = K_SEL;
      A_SDAT_CNT: begin dec_o.kind = K_CNT; dec_o.idx = sel_i; end
      A_SDAT_TYP: begin dec_o.kind = K_TYP; dec_o.idx = sel_i; end
      A_CYC:      dec_o.kind = K_CYC;
      A_CEN_SET:  dec_o.kind = K_CEN_S;
      A_CEN_CLR:  dec_o.kind = K_CEN_C;
      A_IEN_SET:  dec_o.kind = K_IEN_S;
      A_IEN_CLR:  dec_o.kind = K_IEN_C;
      A_OVF_SET:  dec_o.kind = K_OVF_S;
      A_OVF_CLR:  dec_o.kind = K_OVF_C;
      default: begin
        if (addr_i[AW-1:IDXW] == PAGE_CNT) begin
          dec_o.kind = K_CNT;
          dec_o.idx  = addr_i[IDXW-1:0];
        end else if (addr_i[AW-1:IDXW] == PAGE_TYP) begin
          dec_o.kind = K_TYP;
          dec_o.idx  = addr_i[IDXW-1:0];
        end
      end
    endcase
  end

  assign idx_ok_o = (dec_o.idx < n_i);
  assign err_o    = (wr_i || rd_i) && (dec_o.kind == K_CNT || dec_o.kind == K_TYP) && !idx_ok_o;
endmodule

// File: rtl/pmu_bitmap_reg.sv
module pmu_bitmap_reg
  import pmu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_we_i,
  input  logic          clr_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] hw_set_i,
  input  logic [DW-1:0] mask_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] setv, clrv;
  assign setv = set_we_i ? wdata_i : '0;
  assign clrv = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= bitmap_next(q_o, setv, clrv, hw_set_i, mask_i);
  end
endmodule

// File: rtl/pmu_ctr_slice.sv
module pmu_ctr_slice
  import pmu_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          count_en_i,
  input  logic          clr_all_i,
  input  logic          cnt_we_i,
  input  logic [CW-1:0] cnt_wd_i,
  input  logic          typ_we_i,
  input  logic [DW-1:0] typ_wd_i,
  output logic [CW-1:0] cnt_q_o,
  output logic [DW-1:0] typ_q_o,
  output logic          wrap_o
);
  // clear-all beats a register write, which beats an event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q_o <= '0;
    else if (clr_all_i)  cnt_q_o <= '0;
    else if (cnt_we_i)   cnt_q_o <= cnt_wd_i;
    else if (count_en_i) cnt_q_o <= cnt_q_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        typ_q_o <= '0;
    else if (typ_we_i) typ_q_o <= typ_wd_i & TYPE_KEEP;
  end

  assign wrap_o = count_en_i && !clr_all_i && !cnt_we_i && (&cnt_q_o);
endmodule

// File: rtl/pmu_counter_bank.sv
module pmu_counter_bank
  import pmu_pkg::*;
#(
  parameter int unsigned HW_CTRS = 6,
  parameter int unsigned CW      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [AW-1:0]      reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  output logic               reg_err_o,
  input  logic [HW_CTRS-1:0] event_i,
  output logic               irq_o
);
  localparam logic [IDXW-1:0] N_LIMIT = IDXW'(HW_CTRS);

  function automatic logic [DW-1:0] widen(input logic [CW-1:0] v);
    logic [DW-1:0] r;
    r = '0;
    r[CW-1:0] = v;
    return r;
  endfunction

  logic            en_q;
  logic [IDXW-1:0] n_q, n_next, sel_q;
  logic [CW-1:0]   cyc_q;
  logic [DW-1:0]   cen_q, ien_q, ovf_q;
  logic [DW-1:0]   impl_mask_q, mask_next, ovf_hw;
  dec_t            dec;
  logic            idx_ok, acc_err, wr_ok;
  logic            ctrl_we, rst_all, cyc_we, cyc_inc, cyc_wrap;
  logic [HW_CTRS-1:0] cnt_we_vec, typ_we_vec, wrap_vec;
  logic            cnt_we_any, typ_we_any, ev_cnt_or;
  logic [CW-1:0]   cnt_q [HW_CTRS];
  logic [DW-1:0]   typ_q [HW_CTRS];
  logic [CW-1:0]   cnt_at;
  logic [DW-1:0]   typ_at;

  pmu_addr_decode u_dec (
    .addr_i(reg_addr_i), .sel_i(sel_q), .n_i(n_q),
    .wr_i(reg_wr_i), .rd_i(reg_rd_i),
    .dec_o(dec), .idx_ok_o(idx_ok), .err_o(acc_err)
  );

  assign wr_ok   = reg_wr_i && !acc_err;
  assign ctrl_we = wr_ok && (dec.kind == K_CTRL);
  assign rst_all = ctrl_we && reg_wdata_i[CTRL_RST];
  assign n_next  = ctrl_we ? n_accept(n_q, reg_wdata_i[CTRL_N_LSB +: IDXW], N_LIMIT) : n_q;
  assign mask_next   = impl_mask(n_next);
  assign impl_mask_q = impl_mask(n_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      n_q   <= N_LIMIT;
      sel_q <= '0;
    end else begin
      n_q <= n_next;
      if (ctrl_we) en_q <= reg_wdata_i[CTRL_EN];
      if (wr_ok && dec.kind == K_SEL) sel_q <= reg_wdata_i[IDXW-1:0];
    end
  end

  // cycle counter
  assign cyc_we   = wr_ok && (dec.kind == K_CYC);
  assign cyc_inc  = en_q && cen_q[CYC_BIT];
  assign cyc_wrap = cyc_inc && !cyc_we && (&cyc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cyc_q <= '0;
    else if (cyc_we)  cyc_q <= reg_wdata_i[CW-1:0];
    else if (cyc_inc) cyc_q <= cyc_q + 1'b1;
  end

  // event counters
  for (genvar g = 0; g < HW_CTRS; g++) begin : g_ctr
    assign cnt_we_vec[g] = wr_ok && (dec.kind == K_CNT) && (dec.idx == IDXW'(g));
    assign typ_we_vec[g] = wr_ok && (dec.kind == K_TYP) && (dec.idx == IDXW'(g));
    pmu_ctr_slice #(.CW(CW)) u_slice (
      .clk(clk), .rst_n(rst_n),
      .count_en_i(en_q && cen_q[g] && event_i[g]),
      .clr_all_i(rst_all),
      .cnt_we_i(cnt_we_vec[g]), .cnt_wd_i(reg_wdata_i[CW-1:0]),
      .typ_we_i(typ_we_vec[g]), .typ_wd_i(reg_wdata_i),
      .cnt_q_o(cnt_q[g]), .typ_q_o(typ_q[g]), .wrap_o(wrap_vec[g])
    );
  end

  assign cnt_we_any = |cnt_we_vec;
  assign typ_we_any = |typ_we_vec;

  always_comb begin
    ovf_hw = '0;
    ovf_hw[HW_CTRS-1:0] = wrap_vec;
    ovf_hw[CYC_BIT] = cyc_wrap;
  end

  // bitmaps
  pmu_bitmap_reg u_cen (
    .clk(clk), .rst_n(rst_n),
    .set_we_i(wr_ok && dec.kind == K_CEN_S), .clr_we_i(wr_ok && dec.kind == K_CEN_C),
    .wdata_i(reg_wdata_i), .hw_set_i('0), .mask_i(mask_next), .q_o(cen_q)
  );
  pmu_bitmap_reg u_ien (
    .clk(clk), .rst_n(rst_n),
    .set_we_i(wr_ok && dec.kind == K_IEN_S), .clr_we_i(wr_ok && dec.kind == K_IEN_C),
    .wdata_i(reg_wdata_i), .hw_set_i('0), .mask_i(mask_next), .q_o(ien_q)
  );
  pmu_bitmap_reg u_ovf (
    .clk(clk), .rst_n(rst_n),
    .set_we_i(wr_ok && dec.kind == K_OVF_S), .clr_we_i(wr_ok && dec.kind == K_OVF_C),
    .wdata_i(reg_wdata_i), .hw_set_i(ovf_hw), .mask_i(mask_next), .q_o(ovf_q)
  );

  assign irq_o = |(ovf_q & ien_q);

  // read path
  always_comb begin
    cnt_at    = '0;
    typ_at    = '0;
    ev_cnt_or = 1'b0;
    for (int i = 0; i < int'(HW_CTRS); i++) begin
      if (dec.idx == IDXW'(i)) begin
        cnt_at = cnt_q[i];
        typ_at = typ_q[i];
      end
      ev_cnt_or = ev_cnt_or | (|cnt_q[i]);
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (dec.kind)
      K_CTRL: begin
        reg_rdata_o[CTRL_EN] = en_q;
        reg_rdata_o[CTRL_N_LSB +: IDXW] = n_q;
      end
      K_SEL:            reg_rdata_o[IDXW-1:0] = sel_q;
      K_CYC:            reg_rdata_o = widen(cyc_q);
      K_CEN_S, K_CEN_C: reg_rdata_o = cen_q;
      K_IEN_S, K_IEN_C: reg_rdata_o = ien_q;
      K_OVF_S, K_OVF_C: reg_rdata_o = ovf_q;
      K_CNT:            reg_rdata_o = idx_ok ? widen(cnt_at) : '0;
      K_TYP:            reg_rdata_o = idx_ok ? typ_at : '0;
      default:          reg_rdata_o = '0;
    endcase
  end

  assign reg_err_o = acc_err;
endmodule

// File: rtl/pmu_counter_bank_chk.sv
module pmu_counter_bank_chk
  import pmu_pkg::*;
#(
  parameter int unsigned HW_CTRS = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr_i,
  input logic            reg_rd_i,
  input logic [AW-1:0]   reg_addr_i,
  input logic [DW-1:0]   reg_wdata_i,
  input logic            reg_err_o,
  input logic            irq_o,
  input logic            en_q,
  input logic [IDXW-1:0] n_q,
  input logic [DW-1:0]   impl_mask_q,
  input logic [DW-1:0]   cen_q,
  input logic [DW-1:0]   ien_q,
  input logic [DW-1:0]   ovf_q,
  input logic            ev_cnt_or,
  input logic            cnt_we_any,
  input logic            typ_we_any
);
  a_r2_n_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(n_q) <= int'(HW_CTRS));

  a_r4_raz: assert property (@(posedge clk) disable iff (!rst_n)
    ((cen_q | ien_q | ovf_q) & ~impl_mask_q) == '0);

  a_r7_err_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err_o |-> (!cnt_we_any && !typ_we_any));

  a_r7_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err_o |-> (reg_wr_i || reg_rd_i));

  a_r9_idle_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !reg_wr_i) |=> $stable(ovf_q));

  a_r10_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && !reg_err_o && reg_addr_i == A_CTRL && reg_wdata_i[CTRL_RST]) |=> !ev_cnt_or);

  a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ien_q != '0));
endmodule

bind pmu_counter_bank pmu_counter_bank_chk #(.HW_CTRS(HW_CTRS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_err_o(reg_err_o),
  .irq_o(irq_o), .en_q(en_q), .n_q(n_q), .impl_mask_q(impl_mask_q),
  .cen_q(cen_q), .ien_q(ien_q), .ovf_q(ovf_q), .ev_cnt_or(ev_cnt_or),
  .cnt_we_any(cnt_we_any), .typ_we_any(typ_we_any)
);

// File: tb/pmu_counter_bank_tb.sv
module pmu_counter_bank_tb;
  localparam int NC = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          reg_err, irq;
  logic [NC-1:0] event_i = '0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] mcnt [NC];
  logic [31:0] mtyp [NC];

  always #5 clk = ~clk;

  pmu_counter_bank #(.HW_CTRS(NC), .CW(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .reg_err_o(reg_err), .event_i(event_i), .irq_o(irq)
  );

  function automatic logic [31:0] ctrl_word(input bit en, input bit rst, input int n);
    return (32'(n) << 11) | (32'(rst) << 1) | 32'(en);
  endfunction

  function automatic logic [31:0] used_mask(input int n);
    logic [31:0] m;
    m = 32'h8000_0000;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] type_view(input logic [31:0] v);
    return {v[31], 15'd0, v[15:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic e);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    #1 e = reg_err;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata; e = reg_err;
    reg_rd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    logic [31:0] m;
    void'($urandom(32'd20251));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, d, e); chk("R1 ctrl", d, ctrl_word(0, 0, NC));
    rd(8'h08, d, e); chk("R1 cen", d, 0);
    rd(8'h0B, d, e); chk("R1 ien", d, 0);
    rd(8'h0C, d, e); chk("R1 ovf", d, 0);
    rd(8'h22, d, e); chk("R1 count", d, 0);
    chk("R1 irq", 32'(irq), 0);

    // R2 limit on the in-use count
    wr(8'h00, ctrl_word(0, 0, 3), e); chk("R2 err", 32'(e), 0);
    rd(8'h00, d, e); chk("R2 n=3", d, ctrl_word(0, 0, 3));
    wr(8'h00, ctrl_word(0, 0, NC + 1), e); chk("R2 over err", 32'(e), 0);
    rd(8'h00, d, e); chk("R2 over kept", d, ctrl_word(0, 0, 3));
    wr(8'h00, ctrl_word(0, 0, 31), e);
    rd(8'h00, d, e); chk("R2 31 kept", d, ctrl_word(0, 0, 3));

    // R3 / R4 bitmaps with N=3
    wr(8'h08, 32'hFFFF_FFFF, e);
    rd(8'h08, d, e); chk("R3 cen set", d, used_mask(3));
    rd(8'h09, d, e); chk("R3 cen clr view", d, used_mask(3));
    wr(8'h09, 32'h0000_0002, e);
    rd(8'h08, d, e); chk("R3 cen after clr", d, used_mask(3) & ~32'h2);
    wr(8'h0A, 32'h0000_0018, e);
    rd(8'h0B, d, e); chk("R4 ien above N", d, 0);
    wr(8'h0C, 32'h8000_0001, e);
    rd(8'h0D, d, e); chk("R3 ovf pair", d, 32'h8000_0001);
    wr(8'h00, ctrl_word(0, 0, NC), e);
    rd(8'h0B, d, e); chk("R4 ien not stored", d, 0);
    wr(8'h08, 32'h0000_003F, e);
    rd(8'h08, d, e); chk("R3 cen N=6", d, used_mask(NC));
    wr(8'h00, ctrl_word(0, 0, 2), e);
    rd(8'h08, d, e); chk("R4 cen N=2", d, used_mask(2));
    wr(8'h00, ctrl_word(0, 0, NC), e);
    rd(8'h08, d, e); chk("R4 cen cleared", d, used_mask(2));
    wr(8'h09, 32'hFFFF_FFFF, e);
    wr(8'h0B, 32'hFFFF_FFFF, e);
    wr(8'h0D, 32'hFFFF_FFFF, e);
    rd(8'h0C, d, e); chk("R3 ovf cleared", d, 0);

    // R5 / R8 direct access
    for (int k = 0; k < NC; k++) begin
      mcnt[k] = $urandom;
      mtyp[k] = $urandom;
      wr(8'h20 + 8'(k), mcnt[k], e); chk("R5 cnt wr err", 32'(e), 0);
      wr(8'h40 + 8'(k), mtyp[k], e);
      rd(8'h20 + 8'(k), d, e); chk("R5 cnt", d, mcnt[k]);
      rd(8'h40 + 8'(k), d, e); chk("R8 typ", d, type_view(mtyp[k]));
    end
    wr(8'h41, 32'hFFFF_FFFF, e); mtyp[1] = 32'hFFFF_FFFF;
    rd(8'h41, d, e); chk("R8 typ all ones", d, 32'h8000_FFFF);
    for (int ev = 0; ev < 64; ev += 21) begin
      wr(8'h43, 32'h8000_0000 | 32'(ev), e); mtyp[3] = 32'h8000_0000 | 32'(ev);
      rd(8'h43, d, e); chk("R8 event field", d, 32'h8000_0000 | 32'(ev));
    end

    // R6 random mix of direct and selected paths
    for (int it = 0; it < 30; it++) begin
      int k;
      logic [31:0] v;
      k = int'($urandom_range(NC - 1, 0));
      v = $urandom;
      wr(8'h01, 32'(k), e);
      if ($urandom_range(1, 0) == 1) begin
        wr(8'h02, v, e); mcnt[k] = v;
        rd(8'h20 + 8'(k), d, e); chk("R6 sel wr direct rd", d, v);
        wr(8'h40 + 8'(k), v, e); mtyp[k] = v;
        rd(8'h03, d, e); chk("R6 direct wr sel rd", d, type_view(v));
      end else begin
        wr(8'h20 + 8'(k), v, e); mcnt[k] = v;
        rd(8'h02, d, e); chk("R6 sel cnt rd", d, v);
        wr(8'h03, v, e); mtyp[k] = v;
        rd(8'h40 + 8'(k), d, e); chk("R6 sel typ wr", d, type_view(v));
      end
    end

    // R7 invalid counters with N=4
    wr(8'h00, ctrl_word(0, 0, 4), e);
    wr(8'h24, 32'h1234_5678, e); chk("R7 wr cnt4 err", 32'(e), 1);
    wr(8'h44, 32'h0000_0011, e); chk("R7 wr typ4 err", 32'(e), 1);
    rd(8'h25, d, e); chk("R7 rd cnt5 err", 32'(e), 1);
    wr(8'h01, 32'd5, e);
    wr(8'h03, 32'h0000_0022, e); chk("R7 sel wr err", 32'(e), 1);
    wr(8'h02, 32'h0000_0033, e); chk("R7 sel cnt wr err", 32'(e), 1);
    rd(8'h3F, d, e); chk("R7 idx31 err", 32'(e), 1);
    rd(8'h23, d, e); chk("R7 valid no err", 32'(e), 0);
    wr(8'h00, ctrl_word(0, 0, NC), e);
    rd(8'h24, d, e); chk("R7 cnt4 unchanged", d, mcnt[4]);
    rd(8'h44, d, e); chk("R7 typ4 unchanged", d, type_view(mtyp[4]));
    rd(8'h25, d, e); chk("R7 cnt5 unchanged", d, mcnt[5]);
    rd(8'h45, d, e); chk("R7 typ5 unchanged", d, type_view(mtyp[5]));

    // R10 reset-all
    wr(8'h00, ctrl_word(0, 1, NC), e);
    rd(8'h00, d, e); chk("R10 rst bit reads 0", d, ctrl_word(0, 0, NC));
    for (int k = 0; k < NC; k++) begin
      mcnt[k] = 0;
      rd(8'h20 + 8'(k), d, e); chk("R10 cleared", d, 0);
    end
    rd(8'h42, d, e); chk("R10 type kept", d, type_view(mtyp[2]));

    // R9 counting under random enable mask
    m = $urandom & 32'h3F;
    wr(8'h08, m, e);
    wr(8'h00, ctrl_word(1, 0, NC), e);
    for (int c = 0; c < 40; c++) begin
      logic [NC-1:0] ev;
      ev = NC'($urandom);
      @(negedge clk); event_i = ev;
      for (int k = 0; k < NC; k++) if (ev[k] && m[k]) mcnt[k]++;
    end
    @(negedge clk); event_i = '0;
    for (int k = 0; k < NC; k++) begin
      rd(8'h20 + 8'(k), d, e); chk("R9 count", d, mcnt[k]);
    end
    wr(8'h00, ctrl_word(0, 0, NC), e);
    wr(8'h08, 32'h3F, e);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk); event_i = '1;
    end
    @(negedge clk); event_i = '0;
    for (int k = 0; k < NC; k++) begin
      rd(8'h20 + 8'(k), d, e); chk("R9 disabled", d, mcnt[k]);
    end

    // R11 overflow and interrupt
    wr(8'h22, 32'hFFFF_FFFF, e);
    wr(8'h00, ctrl_word(1, 0, NC), e);
    @(negedge clk); event_i = 6'b000100;
    @(negedge clk); event_i = '0;
    wr(8'h00, ctrl_word(0, 0, NC), e);
    rd(8'h22, d, e); chk("R11 wrapped", d, 0);
    rd(8'h0C, d, e); chk("R11 ovf bit", d, 32'h4);
    chk("R11 irq off", 32'(irq), 0);
    wr(8'h0A, 32'h4, e);
    @(negedge clk); chk("R11 irq on", 32'(irq), 1);
    wr(8'h0D, 32'h4, e);
    @(negedge clk); chk("R11 irq cleared", 32'(irq), 0);

    // R12 cycle counter
    wr(8'h09, 32'h3F, e);
    wr(8'h08, 32'h8000_0000, e);
    wr(8'h04, 32'd100, e);
    wr(8'h00, ctrl_word(1, 0, NC), e);
    repeat (7) @(negedge clk);
    wr(8'h00, ctrl_word(0, 0, NC), e);
    rd(8'h04, d, e); chk("R12 cycles", d, 32'd109);
    rd(8'h0C, d, e); chk("R12 no ovf", d, 0);
    wr(8'h04, 32'hFFFF_FFFE, e);
    wr(8'h00, ctrl_word(1, 0, NC), e);
    repeat (3) @(negedge clk);
    wr(8'h00, ctrl_word(0, 0, NC), e);
    rd(8'h04, d, e); chk("R12 cycle wrap", d, 32'd3);
    rd(8'h0C, d, e); chk("R12 ovf bit31", d, 32'h8000_0000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule